// File: doc/BRIEF.md
# Signed/Unsigned Rounding Multiplier Unit

This block is the multiplier datapath of a 16-bit DSP core. It keeps a multiplier register and a product-high register. It also keeps a sticky signedness mode bit, which the wider status register mirrors. The multiplier register is filled by one of two load commands. The load command chosen also sets the mode: a signed load gives two's-complement arithmetic and an unsigned load gives unsigned arithmetic.

A multiply command takes a 16-bit operand. It multiplies the operand by the multiplier register in the current mode to form a 32-bit product and writes the upper half of that product to product-high. The rounding variant first adds one half of the product-high LSB.

Each command is presented for one cycle with `valid_i`. It completes on that clock edge, and `done_o` pulses in the following cycle. Both loads update a pair of transfer flags taken from the value that was moved. The multiplies leave every flag alone.

Top module: `mul_round_unit`

## Requirements
- R1: A valid command with `cmd_i`=2'b00 (signed load) writes `opnd_i` into the multiplier register and clears `unsigned_o` to 0 from the next cycle.
- R2: A valid command with `cmd_i`=2'b01 (unsigned load) writes `opnd_i` into the multiplier register and sets `unsigned_o` to 1 from the next cycle.
- R3: A valid command with `cmd_i`=2'b10 (plain multiply) in signed mode treats both the multiplier register and `opnd_i` as two's complement, and places bits 31:16 of the 32-bit product on `ph_o` from the next cycle.
- R4: The plain multiply in unsigned mode treats both the multiplier register and `opnd_i` as unsigned, and places bits 31:16 of the product on `ph_o` from the next cycle.
- R5: A valid command with `cmd_i`=2'b11 (rounding multiply) adds 0x00008000 to the 32-bit product in the current mode, wrapping modulo 2^32, and places bits 31:16 of the sum on `ph_o` from the next cycle.
- R6: Both loads update the transfer flags from the loaded value: `xfer_zero_o` = (`opnd_i` == 0) and `xfer_neg_o` = `opnd_i`[15].
- R7: Neither multiply command changes `unsigned_o`, `xfer_zero_o` or `xfer_neg_o`.
- R8: `done_o` is high for exactly the one cycle after each cycle in which `valid_i` is high, and is low otherwise.
- R9: `ph_o` keeps its value through idle cycles and through both load commands.
- R10: After reset, `ph_o`=0, the multiplier register is 0, `unsigned_o`=0, `xfer_zero_o`=0, `xfer_neg_o`=0 and `done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Command valid for this cycle |
| cmd_i | input | 2 | 00 signed load, 01 unsigned load, 10 multiply, 11 rounding multiply |
| opnd_i | input | 16 | Memory operand |
| done_o | output | 1 | Command completed (one-cycle pulse) |
| ph_o | output | 16 | Product-high register |
| unsigned_o | output | 1 | Multiplier mode: 1 unsigned, 0 signed |
| xfer_zero_o | output | 1 | Transfer flag: last loaded value was zero |
| xfer_neg_o | output | 1 | Transfer flag: bit 15 of last loaded value |

## Verification
Every result takes effect at the clock edge that samples `valid_i`: product-high, the mode bit, the transfer flags and `done_o` all show their new values in the cycle that follows, so the latency is one cycle. The bench drives inputs on the falling edge and updates its model at the rising edge. It then compares all outputs at the next falling edge, once per cycle, including idle cycles, so a late, early or unwanted change shows up in the cycle where it happens. The operands include 0x8000, 0xFFFF, 0x7FFF and 0 in both modes, mixed with pseudo-random values.

// File: rtl/mru_pkg.sv
package mru_pkg;
  typedef enum logic [1:0] {
    CMD_LDS  = 2'b00,
    CMD_LDU  = 2'b01,
    CMD_MUL  = 2'b10,
    CMD_MULR = 2'b11
  } mru_cmd_e;

  function automatic logic is_load(mru_cmd_e c);
    return (c == CMD_LDS) || (c == CMD_LDU);
  endfunction

  function automatic logic is_mult(mru_cmd_e c);
    return (c == CMD_MUL) || (c == CMD_MULR);
  endfunction
endpackage

// File: rtl/mru_mult.sv
module mru_mult #(
  parameter int W = 16
) (
  input  logic [W-1:0] mr_i,
  input  logic [W-1:0] opnd_i,
  input  logic         unsigned_i,
  input  logic         round_i,
  output logic [W-1:0] hi_o
);
  localparam int EW = W + 1;
  localparam int PW = 2 * W;
  localparam logic [PW-1:0] HALF_LSB = PW'(1) << (W - 1);

  logic signed [EW-1:0]   a_ext, b_ext;
  logic signed [2*EW-1:0] full;
  logic [PW-1:0]          prod, sum;

  // one extra bit carries sign or zero, so a single signed multiplier serves both modes
  always_comb begin
    a_ext = {(~unsigned_i) & mr_i[W-1], mr_i};
    b_ext = {(~unsigned_i) & opnd_i[W-1], opnd_i};
    full  = a_ext * b_ext;
    prod  = full[PW-1:0];
    sum   = prod + (round_i ? HALF_LSB : '0);
    hi_o  = sum[PW-1:W];
  end
endmodule

// File: rtl/mru_regs.sv
module mru_regs #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mr_we_i,
  input  logic         ph_we_i,
  input  logic [W-1:0] opnd_i,
  input  logic [W-1:0] ph_d_i,
  output logic [W-1:0] mr_o,
  output logic [W-1:0] ph_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mr_o <= '0;
      ph_o <= '0;
    end else begin
      if (mr_we_i) mr_o <= opnd_i;
      if (ph_we_i) ph_o <= ph_d_i;
    end
  end
endmodule

// File: rtl/mru_status.sv
module mru_status #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         load_i,
  input  logic         load_u_i,
  input  logic [W-1:0] opnd_i,
  output logic         unsigned_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic         done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unsigned_o <= 1'b0;
      zero_o     <= 1'b0;
      neg_o      <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (load_i) begin
        unsigned_o <= load_u_i;
        zero_o     <= (opnd_i == '0);
        neg_o      <= opnd_i[W-1];
      end
    end
  end
endmodule

// File: rtl/mul_round_unit.sv
module mul_round_unit #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        cmd_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] ph_o,
  output logic              unsigned_o,
  output logic              xfer_zero_o,
  output logic              xfer_neg_o
);
  import mru_pkg::*;

  mru_cmd_e          cmd;
  logic              do_load, do_mult;
  logic [DATA_W-1:0] mr_q, hi_d;

  assign cmd     = mru_cmd_e'(cmd_i);
  assign do_load = valid_i && is_load(cmd);
  assign do_mult = valid_i && is_mult(cmd);

  mru_mult #(.W(DATA_W)) u_mult (
    .mr_i      (mr_q),
    .opnd_i    (opnd_i),
    .unsigned_i(unsigned_o),
    .round_i   (cmd == CMD_MULR),
    .hi_o      (hi_d)
  );

  mru_regs #(.W(DATA_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mr_we_i(do_load),
    .ph_we_i(do_mult),
    .opnd_i (opnd_i),
    .ph_d_i (hi_d),
    .mr_o   (mr_q),
    .ph_o   (ph_o)
  );

  mru_status #(.W(DATA_W)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .load_i    (do_load),
    .load_u_i  (cmd == CMD_LDU),
    .opnd_i    (opnd_i),
    .unsigned_o(unsigned_o),
    .zero_o    (xfer_zero_o),
    .neg_o     (xfer_neg_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/mru_chk.sv
module mru_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        cmd_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic              done_o,
  input logic [DATA_W-1:0] ph_o,
  input logic              unsigned_o,
  input logic              xfer_zero_o,
  input logic              xfer_neg_o
);
  // R1
  signed_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cmd_i == 2'b00) |=> !unsigned_o);
  // R2
  unsigned_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cmd_i == 2'b01) |=> unsigned_o);
  // R3
  zero_product_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cmd_i == 2'b10 && opnd_i == '0) |=> (ph_o == '0));
  // R6
  xfer_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cmd_i[1]) |=> (xfer_zero_o == ($past(opnd_i) == '0)) &&
                               (xfer_neg_o == $past(opnd_i[DATA_W-1])));
  // R7
  mult_keeps_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cmd_i[1]) |=> $stable(unsigned_o) && $stable(xfer_zero_o) && $stable(xfer_neg_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  // R8
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  // R9
  ph_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || !cmd_i[1]) |=> $stable(ph_o));
endmodule

bind mul_round_unit mru_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mul_round_unit_bench.sv
`timescale 1ns/1ps
module mul_round_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic [15:0] opnd = '0;
  logic        done, uns, fz, fn;
  logic [15:0] ph;

  int checks = 0;
  int failures = 0;

  // reference state
  longint m_mr = 0;
  longint m_ph = 0;
  bit m_um = 0, m_z = 0, m_n = 0, m_done = 0;

  always #2 clk = ~clk;

  mul_round_unit u_mul_round_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .cmd_i(cmd), .opnd_i(opnd),
    .done_o(done), .ph_o(ph), .unsigned_o(uns), .xfer_zero_o(fz), .xfer_neg_o(fn)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic longint ext(longint v, bit um);
    if (um) return v & 64'hFFFF;
    return (v & 64'h8000) ? ((v & 64'hFFFF) - 64'h10000) : (v & 64'hFFFF);
  endfunction

  // present one cycle of input at negedge, model at posedge, compare at next negedge
  task automatic step(bit v, logic [1:0] c, logic [15:0] op);
    string rph, rst, rfl;
    longint p;
    valid = v; cmd = c; opnd = op;
    @(posedge clk);
    rph = "R9"; rst = "R7"; rfl = "R7";
    if (v) begin
      if (c == 2'b00 || c == 2'b01) begin
        m_mr = op; m_um = (c == 2'b01);
        m_z = (op == 0); m_n = op[15];
        rst = m_um ? "R2" : "R1"; rfl = "R6";
      end else begin
        p = ext(m_mr, m_um) * ext(op, m_um);
        if (c == 2'b11) begin p = p + 64'h8000; rph = "R5"; end
        else rph = m_um ? "R4" : "R3";
        p = p & 64'hFFFF_FFFF;
        m_ph = (p >> 16) & 64'hFFFF;
      end
    end
    m_done = v;
    @(negedge clk);
    chk(rph, ph, m_ph);
    chk(rst, uns, m_um);
    chk(rfl, {fz, fn}, {m_z, m_n});
    chk("R8", done, m_done);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    #1;
    // R10 reset state
    chk("R10", {ph, uns, fz, fn, done}, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", {ph, uns, fz, fn, done}, 0);
    step(1, 2'b10, 16'h1234);          // R3 with reset MR=0
    // signed corners
    step(1, 2'b00, 16'h8000);
    step(1, 2'b10, 16'h8000);
    step(1, 2'b11, 16'h8000);
    step(1, 2'b10, 16'h7FFF);
    step(0, 2'b10, 16'h1111);          // R9 idle
    step(1, 2'b00, 16'hFFFF);
    step(1, 2'b10, 16'hFFFF);
    step(1, 2'b11, 16'h7FFF);
    step(1, 2'b00, 16'h7FFF);
    step(1, 2'b10, 16'h7FFF);
    step(1, 2'b11, 16'h8000);
    step(1, 2'b10, 16'h0000);
    // unsigned corners
    step(1, 2'b01, 16'hFFFF);
    step(1, 2'b10, 16'hFFFF);
    step(1, 2'b11, 16'hFFFF);          // R5 wrap-free top product
    step(1, 2'b01, 16'h8000);
    step(1, 2'b11, 16'h8000);
    step(1, 2'b10, 16'h7FFF);
    step(1, 2'b00, 16'h0000);          // R6 zero flag, R9 hold
    step(1, 2'b11, 16'h0001);
    step(1, 2'b01, 16'h7FFF);
    step(1, 2'b11, 16'h00FF);
    // pseudo-random mix
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], lfsr[3:2], {lfsr[7:0], lfsr[15:8]} ^ 16'h5A3C);
    end
    step(0, 2'b00, 16'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule